// File: doc/BRIEF.md
# ATM GFC Serial Insertion Port

This block sits in the transmit cell path. Cells arrive one byte at a time on a valid/ready stream, each cell marked by a start-of-cell flag on its first byte. They leave on a second valid/ready stream after one register stage. In ATM UNI mode the block rewrites the upper nibble of header byte 0 with a Generic Flow Control value. That value comes from an external device over a three-wire serial port, which the block clocks and frames itself.

Each accepted byte 0 starts a serial burst. The burst is four bit periods of a divided-down serial clock, and the MSB strobe is high during the first period. The block samples one data bit on each rising edge of the serial clock, most significant bit first. The nibble gathered while cell N passes becomes the GFC field of cell N+1. If no complete nibble is available when a cell starts, the field becomes 0000. A one-cycle pulse marks each complete 53-byte cell handed downstream.

In clear-channel mode every byte passes unchanged, the serial data input is ignored, and the serial clock, the MSB strobe and the cell pulse stay low.

Back-pressure rules: an input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, `out_data` and `out_soc` hold their values.

Top module: `gfc_insert_port`

## Requirements
- R1: In ATM mode (`atm_mode`=1), an accepted byte with `in_soc`=1 leaves with bits 7:4 replaced by the GFC value and bits 3:0 unchanged. The GFC value is the nibble whose burst completed after the previous accepted start-of-cell, provided it completed before this one.
- R2: Bytes with `in_soc`=0, and every byte in clear-channel mode (`atm_mode`=0), leave unchanged. Each output byte keeps its `out_soc` flag.
- R3: GFC 0000 is inserted when no complete nibble exists: on the first cell after reset, on the first cell after a change into ATM mode, and on a cell whose predecessor's burst did not finish. A burst that starts at edge E0 finishes only if the next start-of-cell is accepted later than edge E0+4·DIV.
- R4: An accepted byte 0 in ATM mode starts a burst of exactly four rising edges on `ser_clk`. Rising edge j (0..3) occurs HALF+j·DIV system clocks after the acceptance edge, with HALF = DIV/2. Each high phase lasts HALF cycles, and `ser_clk` idles low outside bursts.
- R5: `ser_din` is sampled at each rising edge of `ser_clk`. The first sampled bit becomes GFC bit 7 of the header byte (the nibble's MSB).
- R6: `ser_msb` is high throughout the first bit period of a burst and low during the other three. It is high at the first rising edge of `ser_clk` and low at the other three.
- R7: `cell_sent` pulses high for one cycle, in the cycle after the 53rd byte counted from an output start-of-cell is transferred. A cell cut short by a new start-of-cell gives no pulse.
- R8: In clear-channel mode, `ser_clk`, `ser_msb` and `cell_sent` are low from the cycle after the mode input goes low.
- R9: `in_ready` = !`out_valid` || `out_ready`. The output byte and flag hold while it is stalled.
- R10: A start-of-cell accepted during an unfinished burst aborts that burst and restarts a new one from its first bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atm_mode | input | 1 | 1 = ATM UNI mode, 0 = clear-channel mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_soc | input | 1 | Input byte is byte 0 of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is byte 0 of a cell |
| ser_clk | output | 1 | Generated serial clock for the GFC port |
| ser_msb | output | 1 | High during the MSB bit period |
| ser_din | input | 1 | GFC serial data from the external device |
| cell_sent | output | 1 | One-cycle pulse per complete cell sent |

## Verification
The main sweep sends a run of back-to-back cells. The serial device supplies every one of the sixteen nibbles in turn, and the header low nibbles vary. This separates a correct MSB-first capture, and its use one cell later, from bit-order, lag or masking faults. A second run adds periodic output stalls and input gaps, to show that insertion and byte order survive back-pressure. Mode changes into and out of clear-channel check pass-through, a quiet serial port and the forced 0000 after re-entry. A truncated cell forces a burst abort and shows that the restart gives 0000 and that the short cell yields no `cell_sent` pulse.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int GFC_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int CELL_BYTES = 53;
  localparam int SER_DIV    = 8;
endpackage

// File: rtl/gfc_serial_rx.sv
module gfc_serial_rx #(
  parameter int DIV   = 8,
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             ser_din,
  output logic             ser_clk,
  output logic             ser_msb,
  output logic             nib_done,
  output logic [NBITS-1:0] nib
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] C_RISE = CW'(HALF - 1);
  localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);
  localparam logic [BW-1:0] B_LAST = BW'(NBITS - 1);

  logic             active;
  logic             clk_q;
  logic [CW-1:0]    div_cnt;
  logic [BW-1:0]    bit_idx;
  logic [NBITS-1:0] shreg;

  // one burst = NBITS bit periods of DIV system clocks, low half then high half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      clk_q    <= 1'b0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      nib_done <= 1'b0;
    end else begin
      nib_done <= 1'b0;
      if (!enable) begin
        active  <= 1'b0;
        clk_q   <= 1'b0;
        div_cnt <= '0;
        bit_idx <= '0;
      end else if (start) begin
        // a new cell always restarts the burst from its first bit
        active  <= 1'b1;
        clk_q   <= 1'b0;
        div_cnt <= '0;
        bit_idx <= '0;
        shreg   <= '0;
      end else if (active) begin
        if (div_cnt == C_RISE) begin
          clk_q <= 1'b1;
          shreg <= {shreg[NBITS-2:0], ser_din};
        end
        if (div_cnt == C_LAST) begin
          clk_q   <= 1'b0;
          div_cnt <= '0;
          if (bit_idx == B_LAST) begin
            active   <= 1'b0;
            nib_done <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign ser_clk = clk_q;
  assign ser_msb = active && (bit_idx == '0);
  assign nib     = shreg;
endmodule

// File: rtl/gfc_nib_hold.sv
module gfc_nib_hold #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             nib_done,
  input  logic [NBITS-1:0] nib,
  input  logic             take,
  output logic [NBITS-1:0] gfc
);
  logic             have;
  logic [NBITS-1:0] held;

  // a nibble finishing in the same cycle as the header is forwarded directly
  assign gfc = nib_done ? nib : (have ? held : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      held <= '0;
    end else if (!enable || take) begin
      have <= 1'b0;
    end else if (nib_done) begin
      have <= 1'b1;
      held <= nib;
    end
  end
endmodule

// File: rtl/gfc_hdr_stage.sv
module gfc_hdr_stage #(
  parameter int DW    = 8,
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert_en,
  input  logic [NBITS-1:0] gfc,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_soc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_soc
);
  localparam int LOW_W = DW - NBITS;

  logic          accept;
  logic [DW-1:0] next_byte;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    next_byte = in_data;
    if (in_soc && insert_en) next_byte = {gfc, in_data[LOW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_soc   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= next_byte;
      out_soc   <= in_soc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gfc_cell_count.sv
module gfc_cell_count #(
  parameter int CELL_LEN = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic xfer,
  input  logic soc,
  output logic cell_sent
);
  localparam int CW = $clog2(CELL_LEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(CELL_LEN);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;

  // zero means "not inside a cell"; bytes without a preceding start are not counted
  always_comb begin
    if (soc)             nxt = CW'(1);
    else if (cnt == '0)  nxt = '0;
    else                 nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cell_sent <= 1'b0;
    end else begin
      cell_sent <= 1'b0;
      if (xfer) begin
        if (nxt == LAST_CNT) begin
          cnt       <= '0;
          cell_sent <= enable;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/gfc_insert_port.sv
module gfc_insert_port
  import gfc_pkg::*;
#(
  parameter int DIV      = SER_DIV,
  parameter int DW       = BYTE_W,
  parameter int NBITS    = GFC_W,
  parameter int CELL_LEN = CELL_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          atm_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_soc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_soc,
  output logic          ser_clk,
  output logic          ser_msb,
  input  logic          ser_din,
  output logic          cell_sent
);
  logic             hdr_take;
  logic             nib_done;
  logic [NBITS-1:0] nib;
  logic [NBITS-1:0] gfc;

  assign hdr_take = in_valid && in_ready && in_soc && atm_mode;

  gfc_serial_rx #(.DIV(DIV), .NBITS(NBITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (atm_mode),
    .start    (hdr_take),
    .ser_din  (ser_din),
    .ser_clk  (ser_clk),
    .ser_msb  (ser_msb),
    .nib_done (nib_done),
    .nib      (nib)
  );

  gfc_nib_hold #(.NBITS(NBITS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (atm_mode),
    .nib_done (nib_done),
    .nib      (nib),
    .take     (hdr_take),
    .gfc      (gfc)
  );

  gfc_hdr_stage #(.DW(DW), .NBITS(NBITS)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .insert_en (atm_mode),
    .gfc       (gfc),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_soc    (in_soc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_soc   (out_soc)
  );

  gfc_cell_count #(.CELL_LEN(CELL_LEN)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (atm_mode),
    .xfer      (out_valid && out_ready),
    .soc       (out_soc),
    .cell_sent (cell_sent)
  );
endmodule

// File: rtl/gfc_insert_port_chk.sv
module gfc_insert_port_chk #(
  parameter int DIV   = 8,
  parameter int DW    = 8,
  parameter int NBITS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          atm_mode,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          in_soc,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_soc,
  input logic          ser_clk,
  input logic          ser_msb,
  input logic          cell_sent
);
  localparam int HALF  = DIV / 2;
  localparam int LOW_W = DW - NBITS;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

  p_pass_body_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_soc) |=> (out_data == $past(in_data) && !out_soc));

  p_pass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !atm_mode) |=> (out_data == $past(in_data)));

  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_soc) |=> (out_soc && out_data[LOW_W-1:0] == $past(in_data[LOW_W-1:0])));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !atm_mode |=> (!ser_clk && !ser_msb && !cell_sent));

  p_msb_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_msb) |-> !ser_clk);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (atm_mode && in_valid && in_ready && in_soc) |=> (ser_msb && !ser_clk));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_sent |=> !cell_sent);

  // high phase of the serial clock never exceeds half a bit period (R4)
  int unsigned hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= 0;
    end else if (ser_clk) begin
      p_duty_r4: assert (hi_len < HALF) else $error("serial clock high too long");
      hi_len <= hi_len + 1;
    end else begin
      hi_len <= 0;
    end
  end
endmodule

bind gfc_insert_port gfc_insert_port_chk #(.DIV(DIV), .DW(DW), .NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .atm_mode  (atm_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_soc    (in_soc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_soc   (out_soc),
  .ser_clk   (ser_clk),
  .ser_msb   (ser_msb),
  .cell_sent (cell_sent)
);

// File: tb/gfc_insert_port_test.sv
module gfc_insert_port_test;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int CELL  = 53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       atm_mode = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_soc = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_soc;
  logic       ser_clk, ser_msb, ser_din, cell_sent;

  gfc_insert_port #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .atm_mode(atm_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_soc(in_soc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc),
    .ser_clk(ser_clk), .ser_msb(ser_msb), .ser_din(ser_din), .cell_sent(cell_sent)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit stall_en = 0;
  bit done_flag = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_en ? ((cyc % 5) != 0) : 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // external serial device: MSB first, index reset by the strobe, advanced on falling clock
  logic [3:0] dev_nib = 4'h0;
  logic [1:0] dev_idx = 2'd0;
  logic       prev_sclk = 1'b0;
  assign ser_din = dev_nib[~dev_idx];
  always @(negedge clk) begin
    if (ser_msb) dev_idx <= 2'd0;
    else if (prev_sclk && !ser_clk && dev_idx != 2'd3) dev_idx <= dev_idx + 2'd1;
    prev_sclk <= ser_clk;
  end

  // expected output stream: {last, soc, byte}
  logic [9:0] expq[$];
  int  rise_cnt = 0;
  int  soc_cyc  = 0;
  bit  have_prev = 0;
  int  prev_cyc  = 0;
  logic [3:0] prev_nib = 4'h0;
  logic mon_prev_sclk = 1'b0;
  bit  last_pend = 0;

  // monitor just before each rising edge
  always @(negedge clk) begin
    #(CLK_P/2 - 1);
    if (rst_n) begin
      check("R7 cell_sent", cell_sent, last_pend);
      last_pend = 0;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R2 unexpected byte", 1, 0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check(e[8] ? "R1 header byte" : "R2 body byte", {out_soc, out_data}, e[8:0]);
          last_pend = e[9];
        end
      end
      if (!atm_mode) check("R8 quiet port", {ser_clk, ser_msb}, 0);
      if (ser_clk && !mon_prev_sclk) begin
        rise_cnt++;
        check("R6 strobe at rise", ser_msb, rise_cnt == 1);
        check("R4 rise timing", cyc, soc_cyc + (rise_cnt - 1) * DIV + HALF + 1);
      end
      mon_prev_sclk = ser_clk;
    end
  end

  task automatic send_cell(input logic [3:0] nib, input int nbytes, input int seed, input int gap);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      int at;
      b = 8'((seed * 29) + (i * 13) + 5);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      in_soc   = (i == 0);
      #(CLK_P/2 - 1);
      while (!in_ready) begin
        @(negedge clk);
        #(CLK_P/2 - 1);
      end
      at = cyc;
      if (i == 0) begin
        if (atm_mode) begin
          logic [3:0] g;
          bit full;
          full = have_prev && (at - prev_cyc > 4 * DIV);
          g = full ? prev_nib : 4'h0;
          if (full) check("R4 four rises per cell", rise_cnt, 4);
          expq.push_back({1'b0, 1'b1, g, b[3:0]});
          have_prev = 1;
          prev_cyc  = at;
          prev_nib  = nib;
        end else begin
          have_prev = 0;
          expq.push_back({1'b0, 1'b1, b});
        end
      end else begin
        expq.push_back({(atm_mode && nbytes == CELL && i == CELL - 1), 1'b0, b});
      end
      @(posedge clk);
      #1;
      if (i == 0) begin
        dev_nib  = nib;
        rise_cnt = 0;
        soc_cyc  = at;
      end
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (DIV * 5) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", out_valid, 0);
    check("R4 reset ser_clk", ser_clk, 0);
    check("R6 reset ser_msb", ser_msb, 0);
    check("R7 reset cell_sent", cell_sent, 0);
    check("R9 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R5: sweep all nibbles back to back, each used one cell later
    for (int k = 0; k < 17; k++) send_cell(4'(k), CELL, k, 0);
    drain();

    // R9: back-pressure and input gaps
    stall_en = 1;
    send_cell(4'h5, CELL, 40, 3);
    send_cell(4'hA, CELL, 41, 7);
    send_cell(4'h3, CELL, 42, 2);
    send_cell(4'hC, CELL, 43, 0);
    drain();
    stall_en = 0;

    // R8 R2: clear-channel pass-through
    @(negedge clk);
    atm_mode = 1'b0;
    send_cell(4'hF, CELL, 50, 0);
    send_cell(4'h9, CELL, 51, 4);
    drain();

    // R3: re-entry into ATM mode inserts 0000 first
    @(negedge clk);
    atm_mode = 1'b1;
    repeat (2) @(negedge clk);
    send_cell(4'h7, CELL, 60, 0);
    send_cell(4'hE, CELL, 61, 0);
    send_cell(4'h1, CELL, 62, 0);

    // R10 R7: truncated cell aborts the burst and gives no cell pulse
    send_cell(4'h6, 5, 70, 0);
    send_cell(4'h2, CELL, 71, 0);
    send_cell(4'hB, CELL, 72, 0);
    send_cell(4'h4, CELL, 73, 0);
    drain();

    finish_run();
  end
endmodule